// File: doc/BRIEF.md
# Column Burst Sequencer

This block expands one burst request into the column addresses of the individual beats of a memory read or write burst. A request carries the starting column address, a burst length of 4 or 8 beats and an ordering choice: sequential or interleaved. The block issues one column address per clock. Each address comes with a valid flag, and a last flag marks the final beat.

The low three column bits follow the selected ordering. In sequential mode the two lowest bits count up modulo 4. In an 8-beat burst, bit 2 inverts for the second group of four beats. In interleaved mode the low three bits are the starting bits XORed with the beat index. The bits above bit 2 are copied from the request and do not change during the burst. While a burst is running, further requests are dropped. The one exception is the cycle that carries the last beat: a request in that cycle starts the next burst with no gap.

Top module: `col_burst_seq`

## Requirements
- R1: After reset `beat_valid_o` and `beat_last_o` are 0 and stay 0 until a request is accepted.
- R2: A request (`burst_go_i` high while idle) appears one clock later as `beat_valid_o` = 1, with `beat_col_o` equal to `start_col_i`.
- R3: An accepted burst gives one beat per clock with `beat_valid_o` held high for exactly 4 clocks when `eight_beat_i` = 0 at the request, or 8 clocks when it is 1. After that, `beat_valid_o` falls unless a new request was accepted.
- R4: `beat_last_o` is high only on the final beat, which is beat index 3 of a 4-beat burst or beat index 7 of an 8-beat burst.
- R5: With `interleave_i` = 0 at the request, bits 1..0 of the beat address equal (start + beat index) mod 4. Bit 2 equals start bit 2 XOR beat index bit 2. For example, start 5 in an 8-beat burst gives 5,6,7,4,1,2,3,0.
- R6: With `interleave_i` = 1 at the request, bits 2..0 of the beat address equal start bits 2..0 XOR beat index. For example, start 3 in an 8-beat burst gives 3,2,1,0,7,6,5,4.
- R7: Column bits above bit 2 keep their requested values for the whole burst. In a 4-beat burst, bit 2 also keeps its requested value.
- R8: `burst_go_i` during a beat other than the last one is ignored. The running burst keeps its sequence, its length and its addresses.
- R9: `burst_go_i` in the cycle of the last beat is accepted. The new burst's first beat follows in the next clock, with `beat_valid_o` staying high.
- R10: `start_col_i`, `eight_beat_i` and `interleave_i` are sampled only when a request is accepted. Changes to them during a burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_go_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Starting column address |
| eight_beat_i | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | Current beat is valid |
| beat_last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Two events can fall in the same clock: the issue of a burst's final beat and the arrival of a new request. The bench provokes this by raising the request exactly in the cycle where `beat_last_o` is seen high. It then expects the new burst's first address in the next cycle, with no idle cycle in between. The opposite case is also driven: a request raised in the middle of a burst, together with different mode and address inputs. That case is judged by the original burst running to its end unchanged.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam int BEAT_W = 3;
  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN = 8;
  typedef logic [BEAT_W-1:0] beat_t;
  localparam beat_t SHORT_END = beat_t'(SHORT_LEN - 1);
  localparam beat_t LONG_END = beat_t'(LONG_LEN - 1);
endpackage

// File: rtl/csq_rst_sync.sv
module csq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/csq_beat_ctrl.sv
module csq_beat_ctrl
  import csq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_i,
  input  logic  len8_i,
  output logic  take_o,
  output logic  busy_o,
  output logic  last_o,
  output logic  len8_o,
  output beat_t beat_o
);
  logic  busy_q, busy_d;
  logic  len8_q, len8_d;
  beat_t beat_q, beat_d;
  logic  ena;
  logic  at_end;

  assign at_end = busy_q && (beat_q == (len8_q ? LONG_END : SHORT_END));
  assign take_o = go_i && (!busy_q || at_end);
  assign ena    = take_o || busy_q;

  always_comb begin
    busy_d = busy_q;
    len8_d = len8_q;
    beat_d = beat_q;
    if (take_o) begin
      busy_d = 1'b1;
      len8_d = len8_i;
      beat_d = '0;
    end else if (at_end) begin
      busy_d = 1'b0;
    end else begin
      beat_d = beat_q + beat_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      len8_q <= 1'b0;
      beat_q <= '0;
    end else if (ena) begin
      busy_q <= busy_d;
      len8_q <= len8_d;
      beat_q <= beat_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = at_end;
  assign len8_o = len8_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/csq_order_map.sv
module csq_order_map
  import csq_pkg::*;
(
  input  beat_t base_i,
  input  beat_t idx_i,
  input  logic  ilv_i,
  output beat_t col_o
);
  logic [1:0] low_seq;
  logic [1:0] low_ilv;

  always_comb begin
    low_seq = base_i[1:0] + idx_i[1:0];
    low_ilv = base_i[1:0] ^ idx_i[1:0];
    col_o[2] = base_i[2] ^ idx_i[2];
    col_o[1:0] = ilv_i ? low_ilv : low_seq;
  end
endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import csq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_go_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             eight_beat_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_valid_o,
  output logic             beat_last_o
);
  localparam int UP_W = COL_W - BEAT_W;

  logic             rst_sync_n;
  logic             take;
  logic             busy;
  logic             last;
  logic             len8_q;
  beat_t            beat_q;
  logic [COL_W-1:0] base_q, base_d;
  logic             ilv_q, ilv_d;
  beat_t            low_col;

  csq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csq_beat_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .go_i   (burst_go_i),
    .len8_i (eight_beat_i),
    .take_o (take),
    .busy_o (busy),
    .last_o (last),
    .len8_o (len8_q),
    .beat_o (beat_q)
  );

  always_comb begin
    base_d = base_q;
    ilv_d  = ilv_q;
    if (take) begin
      base_d = start_col_i;
      ilv_d  = interleave_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (take) begin
      base_q <= base_d;
      ilv_q  <= ilv_d;
    end
  end

  csq_order_map u_map (
    .base_i (base_q[BEAT_W-1:0]),
    .idx_i  (beat_q),
    .ilv_i  (ilv_q),
    .col_o  (low_col)
  );

  assign beat_col_o   = {base_q[COL_W-1 -: UP_W], low_col};
  assign beat_valid_o = busy;
  assign beat_last_o  = last;
endmodule

// File: rtl/col_burst_seq_chk.sv
module col_burst_seq_chk
  import csq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             last,
  input logic [COL_W-1:0] col,
  input beat_t            beat_q,
  input logic             len8_q,
  input logic             ilv_q,
  input logic [COL_W-1:0] base_q
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid); // R4
  AST_SHORT_ENDS_AT_3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !len8_q && beat_q == 3'd3) |-> last); // R4
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> valid); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> (beat_q == $past(beat_q) + 3'd1)); // R8
  AST_SEQ_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !ilv_q) |=> (col[1:0] == $past(col[1:0]) + 2'd1)); // R5
  AST_ILV_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ilv_q) |-> ((col[2:0] ^ beat_q) == base_q[2:0])); // R6
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> $stable(col[COL_W-1:3])); // R7
  AST_SHORT_A2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !len8_q) |=> $stable(col[2])); // R7
endmodule

bind col_burst_seq col_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .valid  (beat_valid_o),
  .last   (beat_last_o),
  .col    (beat_col_o),
  .beat_q (beat_q),
  .len8_q (len8_q),
  .ilv_q  (ilv_q),
  .base_q (base_q)
);

// File: tb/col_burst_seq_bench.sv
module col_burst_seq_bench;
  localparam int COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic             burst_go_i;
  logic [COL_W-1:0] start_col_i;
  logic             eight_beat_i;
  logic             interleave_i;
  logic [COL_W-1:0] beat_col_o;
  logic             beat_valid_o;
  logic             beat_last_o;

  int checks;
  int errors;
  int cycles;

  col_burst_seq #(.COL_W(COL_W)) u_col_burst_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_go_i   (burst_go_i),
    .start_col_i  (start_col_i),
    .eight_beat_i (eight_beat_i),
    .interleave_i (interleave_i),
    .beat_col_o   (beat_col_o),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int ref_low(int a, int i, bit ilv);
    int lo;
    int hi;
    if (ilv) return a ^ i;
    lo = ((a % 4) + (i % 4)) % 4;
    hi = ((a / 4) + (i / 4)) % 2;
    return hi * 4 + lo;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(int a, int up, bit len8, bit ilv);
    burst_go_i   = 1'b1;
    start_col_i  = COL_W'(up * 8 + a);
    eight_beat_i = len8;
    interleave_i = ilv;
    @(negedge clk);
    burst_go_i   = 1'b0;
    start_col_i  = ~start_col_i;
    eight_beat_i = ~len8;
    interleave_i = ~ilv;
  endtask

  task automatic check_beats(int a, int up, bit len8, bit ilv, bit expect_idle);
    int n = len8 ? 8 : 4;
    for (int b = 0; b < n; b++) begin
      chk(beat_valid_o == 1'b1, "R2 R3 valid during burst", int'(beat_valid_o), 1);
      chk(int'(beat_col_o) == up * 8 + ref_low(a, b, ilv),
          ilv ? "R6 R7 R10 interleaved address" : "R5 R7 R10 sequential address",
          int'(beat_col_o), up * 8 + ref_low(a, b, ilv));
      chk(beat_last_o == (b == n - 1), "R4 last flag", int'(beat_last_o), int'(b == n - 1));
      if (b != n - 1) @(negedge clk);
    end
    if (expect_idle) begin
      @(negedge clk);
      chk(beat_valid_o == 1'b0, "R3 valid falls after burst", int'(beat_valid_o), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    burst_go_i = 1'b0;
    start_col_i = '0;
    eight_beat_i = 1'b0;
    interleave_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(beat_valid_o == 1'b0, "R1 valid in reset", int'(beat_valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(beat_valid_o == 1'b0, "R1 valid after reset", int'(beat_valid_o), 0);
    chk(beat_last_o == 1'b0, "R1 last after reset", int'(beat_last_o), 0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        launch(a, 7 * a + m + 1, m[1], m[0]);
        check_beats(a, 7 * a + m + 1, m[1], m[0], 1'b1);
      end
    end
  endtask

  task automatic t_ignore_mid();
    launch(5, 21, 1'b1, 1'b0);
    for (int b = 0; b < 8; b++) begin
      chk(int'(beat_col_o) == 21 * 8 + ref_low(5, b, 1'b0), "R8 R10 mid-burst request ignored",
          int'(beat_col_o), 21 * 8 + ref_low(5, b, 1'b0));
      chk(beat_last_o == (b == 7), "R8 length kept", int'(beat_last_o), int'(b == 7));
      burst_go_i   = (b == 2);
      start_col_i  = COL_W'(3);
      eight_beat_i = 1'b0;
      interleave_i = 1'b1;
      @(negedge clk);
    end
    burst_go_i = 1'b0;
    chk(beat_valid_o == 1'b0, "R8 no burst from ignored request", int'(beat_valid_o), 0);
  endtask

  task automatic t_back_to_back();
    launch(2, 9, 1'b0, 1'b0);
    check_beats(2, 9, 1'b0, 1'b0, 1'b0);
    chk(beat_last_o == 1'b1, "R9 last seen before chained request", int'(beat_last_o), 1);
    launch(3, 40, 1'b1, 1'b1);
    check_beats(3, 40, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    cycles = 0;
    t_reset();
    t_sweep();
    t_ignore_mid();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule